// File: doc/BRIEF.md
# Multi-Bank Chip-Select Wait-State Controller

This block sits at the front of an external memory controller. Each bus transfer arrives as a one-cycle start strobe with an address, an address-type code, a direction and a transfer size. The block compares the transfer against eight programmable banks. Each bank has a base address, a power-of-two size from 32 KB to 256 MB, a type code with a type-compare mask, a port width and a wait-state count. When a bank matches, the block drives that bank's active-low chip select. It also drives four active-low byte-lane enables and, for reads, an active-low output enable. It acknowledges the transfer once the bank's wait states have elapsed.

Bank 0 doubles as the boot select. Out of reset it already covers the top 256 MB of the address space. It uses the slowest timing and an 8-bit port, and it accepts any type code, so a processor can fetch its first instructions before any bank is programmed. Software reprograms a bank through a single-cycle write port that loads all of the bank's fields at once. Out-of-range values are clamped as they are written.

Top module: `csws_ctrl`

## Requirements
- R1: After reset, every chip select, byte enable, output enable and the acknowledge are inactive. Bank 0 is valid, covers 0xF000_0000 to 0xFFFF_FFFF, and accepts any type code. It uses 20 wait states and an 8-bit port.
- R2: A valid bank with size code s covers 2^(15+s) bytes. An address belongs to that bank when all address bits from bit 15+s upward equal the same bits of the bank's base.
- R3: A bank also requires ((bus_type XOR bank type) AND bank type-mask) == 0. A mask of zero accepts every type.
- R4: When several banks match a transfer, only the lowest-numbered one is selected, so at most one chip select is ever low.
- R5: A start strobe sampled at clock edge E asserts the selected chip select from E until the end of the transfer. With W wait states, the acknowledge is high for exactly one cycle, the (W+1)-th cycle of chip select. Chip select goes high in the cycle after the acknowledge.
- R6: A programmed wait count above 20 behaves as 20.
- R7: A programmed size code above 13 behaves as 13 (256 MB).
- R8: Lane k (be_n[k]) serves byte offset k of the word. Port code 0 (8-bit) always enables lane 0. Port code 1 (16-bit) enables lane addr[0] for byte transfers and lanes 0–1 otherwise. Port code 2 or 3 (32-bit) enables lane addr[1:0] for bytes, lanes 0–1 or 2–3 (by addr[1]) for halfwords, and all four lanes for words. Size code 0 is byte, 1 is halfword, 2 or 3 is word. All lanes stay high while no chip select is low.
- R9: oe_n is low during the chip-select cycles of a read (bus_rd=1) and high for writes and when idle.
- R10: A transfer that matches no bank produces no chip select and no acknowledge.
- R11: A start strobe that arrives while a transfer is in progress is ignored.
- R12: A bank whose valid flag is cleared is never selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Load all fields of bank cfg_idx this cycle |
| cfg_idx | input | 3 | Bank index to program |
| cfg_valid | input | 1 | Bank enable |
| cfg_base | input | 32 | Bank base address (bits below the bank size are ignored) |
| cfg_size | input | 4 | Size code, 32 KB shifted left by the code |
| cfg_port | input | 2 | Port width code: 0 8-bit, 1 16-bit, 2/3 32-bit |
| cfg_type | input | 3 | Address-type value to compare |
| cfg_tmask | input | 3 | Bits of the type that take part in the compare |
| cfg_wait | input | 5 | Wait-state count |
| bus_start | input | 1 | One-cycle transfer start |
| bus_addr | input | 32 | Transfer address |
| bus_type | input | 3 | Transfer address-type code |
| bus_rd | input | 1 | 1 for read, 0 for write |
| bus_size | input | 2 | Transfer size code |
| cs_n | output | 8 | Active-low bank chip selects |
| be_n | output | 4 | Active-low byte-lane enables |
| oe_n | output | 1 | Active-low output enable |
| ack | output | 1 | Transfer acknowledge |

## Verification
The strobe is driven on a falling edge and captured on the following rising edge. Chip select, byte enables and output enable are therefore already valid at the next falling edge, which the bench counts as cycle 0 of the transfer. The acknowledge is due at cycle W, and chip select must be high again at cycle W+1. The bench samples every falling edge from cycle 0 through W+1 and compares each output with the value its reference model expects for that cycle. Missed transfers, and strobes ignored because a transfer was in progress, are checked over the same window and for a few idle cycles afterwards.

// File: rtl/csws_pkg.sv
package csws_pkg;

  localparam int ADDR_W     = 32;
  localparam int TYPE_W     = 3;
  localparam int WAIT_W     = 5;
  localparam int SIZE_W     = 4;
  localparam int PORT_W     = 2;
  localparam int LANES      = 4;
  localparam int MIN_SHIFT  = 15;
  localparam int MAX_SIZE   = 13;

  typedef struct packed {
    logic              valid;
    logic [ADDR_W-1:0] base;
    logic [SIZE_W-1:0] size;
    logic [PORT_W-1:0] port;
    logic [TYPE_W-1:0] ttype;
    logic [TYPE_W-1:0] tmask;
    logic [WAIT_W-1:0] waits;
  } bank_cfg_t;

  // Address bits that must equal the base for a bank of the given size code
  function automatic logic [ADDR_W-1:0] region_mask(input logic [SIZE_W-1:0] size);
    logic [ADDR_W-1:0] m;
    m = '1;
    m = m << (MIN_SHIFT + int'(size));
    return m;
  endfunction

  // Byte lanes used by a transfer on a port of the given width
  function automatic logic [LANES-1:0] lane_pick(input logic [PORT_W-1:0] port,
                                                 input logic [1:0] xsize,
                                                 input logic [1:0] off);
    logic [LANES-1:0] l;
    unique case (port)
      2'd0: l = 4'b0001;
      2'd1: l = (xsize == 2'd0) ? (4'b0001 << off[0]) : 4'b0011;
      default: begin
        unique case (xsize)
          2'd0:    l = 4'b0001 << off;
          2'd1:    l = off[1] ? 4'b1100 : 4'b0011;
          default: l = 4'b1111;
        endcase
      end
    endcase
    return l;
  endfunction

endpackage

// File: rtl/csws_bank_regs.sv
module csws_bank_regs
  import csws_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int IDX_W     = 3,
  parameter int MAX_WAIT  = 20,
  parameter int BOOT_SIZE = 13,
  parameter int BOOT_PORT = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [IDX_W-1:0]          widx,
  input  bank_cfg_t                 wdata,
  output bank_cfg_t [NUM_BANKS-1:0] cfgs
);

  localparam logic [SIZE_W-1:0] BOOT_SZ = SIZE_W'(BOOT_SIZE);
  localparam logic [WAIT_W-1:0] WAIT_CAP = WAIT_W'(MAX_WAIT);
  localparam logic [SIZE_W-1:0] SIZE_CAP = SIZE_W'(MAX_SIZE);

  bank_cfg_t clamped;

  // Saturate the written fields once, shared by all banks
  always_comb begin
    clamped = wdata;
    if (wdata.waits > WAIT_CAP) clamped.waits = WAIT_CAP;
    if (wdata.size  > SIZE_CAP) clamped.size  = SIZE_CAP;
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    bank_cfg_t cur_q, nxt;
    bank_cfg_t rst_val;

    if (g == 0) begin : g_boot
      assign rst_val = '{valid: 1'b1,
                         base:  region_mask(BOOT_SZ),
                         size:  BOOT_SZ,
                         port:  PORT_W'(BOOT_PORT),
                         ttype: '0,
                         tmask: '0,
                         waits: WAIT_CAP};
    end else begin : g_plain
      assign rst_val = '0;
    end

    always_comb begin
      nxt = cur_q;
      if (we && (widx == IDX_W'(g))) nxt = clamped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= rst_val;
      else        cur_q <= nxt;
    end

    assign cfgs[g] = cur_q;

    AST_WAIT_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      cur_q.waits <= WAIT_CAP); // R6
    AST_SIZE_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      cur_q.size <= SIZE_CAP); // R7
  end

endmodule

// File: rtl/csws_decode.sv
module csws_decode
  import csws_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int IDX_W     = 3
) (
  input  bank_cfg_t [NUM_BANKS-1:0] cfgs,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [TYPE_W-1:0]         atype,
  output logic                      hit,
  output logic [IDX_W-1:0]          idx
);

  logic [NUM_BANKS-1:0] match;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cmp
    logic [ADDR_W-1:0] keep;
    logic              addr_ok;
    logic              type_ok;
    assign keep    = region_mask(cfgs[g].size);
    assign addr_ok = ((addr ^ cfgs[g].base) & keep) == '0;
    assign type_ok = ((atype ^ cfgs[g].ttype) & cfgs[g].tmask) == '0;
    assign match[g] = cfgs[g].valid && addr_ok && type_ok;
  end

  // Lowest-numbered match wins: scan downward so the last write is the lowest
  always_comb begin
    idx = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

  assign hit = |match;

endmodule

// File: rtl/csws_wait_timer.sv
module csws_wait_timer
  import csws_pkg::*;
#(
  parameter int MAX_WAIT = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_wait,
  output logic              busy,
  output logic              done
);

  logic              busy_q, busy_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!busy_q) begin
      if (load) begin
        busy_d = 1'b1;
        cnt_d  = load_wait;
        cnt_en = 1'b1;
      end
    end else if (cnt_q == '0) begin
      busy_d = 1'b0;
    end else begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= WAIT_W'(MAX_WAIT))); // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1)); // R5
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q); // R5

endmodule

// File: rtl/csws_ctrl.sv
module csws_ctrl
  import csws_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int MAX_WAIT  = 20,
  parameter int BOOT_SIZE = 13,
  parameter int BOOT_PORT = 0,
  localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic                 cfg_valid,
  input  logic [ADDR_W-1:0]    cfg_base,
  input  logic [SIZE_W-1:0]    cfg_size,
  input  logic [PORT_W-1:0]    cfg_port,
  input  logic [TYPE_W-1:0]    cfg_type,
  input  logic [TYPE_W-1:0]    cfg_tmask,
  input  logic [WAIT_W-1:0]    cfg_wait,
  input  logic                 bus_start,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [TYPE_W-1:0]    bus_type,
  input  logic                 bus_rd,
  input  logic [1:0]           bus_size,
  output logic [NUM_BANKS-1:0] cs_n,
  output logic [LANES-1:0]     be_n,
  output logic                 oe_n,
  output logic                 ack
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  bank_cfg_t [NUM_BANKS-1:0] cfgs;
  bank_cfg_t                 wdata;

  assign wdata = '{valid: cfg_valid, base: cfg_base, size: cfg_size,
                   port: cfg_port, ttype: cfg_type, tmask: cfg_tmask,
                   waits: cfg_wait};

  csws_bank_regs #(
    .NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W), .MAX_WAIT(MAX_WAIT),
    .BOOT_SIZE(BOOT_SIZE), .BOOT_PORT(BOOT_PORT)
  ) u_regs (
    .clk(clk), .rst_n(rst_i_n), .we(cfg_we), .widx(cfg_idx),
    .wdata(wdata), .cfgs(cfgs)
  );

  logic             hit;
  logic [IDX_W-1:0] hit_idx;

  csws_decode #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_dec (
    .cfgs(cfgs), .addr(bus_addr), .atype(bus_type), .hit(hit), .idx(hit_idx)
  );

  logic busy, done, accept;
  assign accept = bus_start && hit && !busy;

  csws_wait_timer #(.MAX_WAIT(MAX_WAIT)) u_tmr (
    .clk(clk), .rst_n(rst_i_n), .load(accept),
    .load_wait(cfgs[hit_idx].waits), .busy(busy), .done(done)
  );

  // Transfer attributes captured at acceptance
  logic [IDX_W-1:0] sel_q, sel_d;
  logic [LANES-1:0] lanes_q, lanes_d;
  logic             rd_q, rd_d;

  always_comb begin
    sel_d   = hit_idx;
    lanes_d = lane_pick(cfgs[hit_idx].port, bus_size, bus_addr[1:0]);
    rd_d    = bus_rd;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      sel_q   <= '0;
      lanes_q <= '0;
      rd_q    <= 1'b0;
    end else if (accept) begin
      sel_q   <= sel_d;
      lanes_q <= lanes_d;
      rd_q    <= rd_d;
    end
  end

  always_comb begin
    cs_n = '1;
    if (busy) cs_n[sel_q] = 1'b0;
  end

  assign be_n = busy ? ~lanes_q : '1;
  assign oe_n = !(busy && rd_q);
  assign ack  = done;

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(~cs_n)); // R4
  AST_ACK_IN_SELECT: assert property (@(posedge clk) disable iff (!rst_i_n)
    ack |-> !(&cs_n)); // R5
  AST_SELECT_DROPS: assert property (@(posedge clk) disable iff (!rst_i_n)
    ack |=> (&cs_n)); // R5
  AST_IDLE_LANES: assert property (@(posedge clk) disable iff (!rst_i_n)
    (&cs_n) |-> ((&be_n) && oe_n)); // R9
  AST_HOLD_BANK: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && !ack) |=> $stable(cs_n)); // R11

endmodule

// File: tb/tb_csws_ctrl.sv
module tb_csws_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic        cfg_valid = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [3:0]  cfg_size = '0;
  logic [1:0]  cfg_port = '0;
  logic [2:0]  cfg_type = '0;
  logic [2:0]  cfg_tmask = '0;
  logic [4:0]  cfg_wait = '0;
  logic        bus_start = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [2:0]  bus_type = '0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_size = '0;
  logic [7:0]  cs_n;
  logic [3:0]  be_n;
  logic        oe_n;
  logic        ack;

  always #2 clk = ~clk;

  csws_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_valid(cfg_valid), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .cfg_port(cfg_port), .cfg_type(cfg_type), .cfg_tmask(cfg_tmask),
    .cfg_wait(cfg_wait), .bus_start(bus_start), .bus_addr(bus_addr),
    .bus_type(bus_type), .bus_rd(bus_rd), .bus_size(bus_size),
    .cs_n(cs_n), .be_n(be_n), .oe_n(oe_n), .ack(ack)
  );

  int checks = 0;
  int errors = 0;

  // Reference copy of the bank settings, kept from the requirements
  bit          m_valid [8];
  logic [31:0] m_base  [8];
  int          m_size  [8];
  int          m_port  [8];
  logic [2:0]  m_type  [8];
  logic [2:0]  m_tmask [8];
  int          m_wait  [8];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int find_bank(input logic [31:0] a, input logic [2:0] t);
    for (int i = 0; i < 8; i++) begin
      int s;
      s = 15 + m_size[i];
      if (m_valid[i] && ((a >> s) == (m_base[i] >> s)) &&
          (((t ^ m_type[i]) & m_tmask[i]) == 3'b000))
        return i;
    end
    return -1;
  endfunction

  function automatic logic [3:0] exp_lanes(input int port, input int sz,
                                           input logic [1:0] off);
    if (port == 0) return 4'b0001;
    if (port == 1) begin
      if (sz == 0) return off[0] ? 4'b0010 : 4'b0001;
      return 4'b0011;
    end
    if (sz == 0) begin
      case (off)
        2'd0: return 4'b0001;
        2'd1: return 4'b0010;
        2'd2: return 4'b0100;
        default: return 4'b1000;
      endcase
    end
    if (sz == 1) return off[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  task automatic cfg_write(input int b, input bit v, input logic [31:0] base,
                           input int size, input int port, input logic [2:0] t,
                           input logic [2:0] tm, input int w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(b); cfg_valid = v; cfg_base = base;
    cfg_size = 4'(size); cfg_port = 2'(port); cfg_type = t; cfg_tmask = tm;
    cfg_wait = 5'(w);
    @(negedge clk);
    cfg_we = 1'b0;
    m_valid[b] = v; m_base[b] = base;
    m_size[b] = (size > 13) ? 13 : size;   // R7 saturation
    m_port[b] = port; m_type[b] = t; m_tmask[b] = tm;
    m_wait[b] = (w > 20) ? 20 : w;         // R6 saturation
  endtask

  task automatic check_idle(input string req, input int n);
    for (int k = 0; k < n; k++) begin
      chk(cs_n == 8'hFF, req, "idle cs_n", {24'h0, cs_n}, 32'hFF);
      chk(ack == 1'b0, req, "idle ack", {31'h0, ack}, 32'h0);
      @(negedge clk);
    end
  endtask

  // One transfer; optionally a second strobe (probe) during the first cycle
  task automatic access(input logic [31:0] a, input logic [2:0] t,
                        input bit rd, input int sz, input bit probe,
                        input logic [31:0] pa);
    int b, w;
    logic [3:0] ln;
    b = find_bank(a, t);
    @(negedge clk);
    bus_start = 1'b1; bus_addr = a; bus_type = t; bus_rd = rd; bus_size = 2'(sz);
    @(negedge clk);
    bus_start = 1'b0;
    if (b < 0) begin
      check_idle("R10", 4);
      return;
    end
    w  = m_wait[b];
    ln = exp_lanes(m_port[b], sz, a[1:0]);
    for (int k = 0; k <= w + 1; k++) begin
      logic [7:0] ecs;
      ecs = (k <= w) ? ~(8'h01 << b) : 8'hFF;
      chk(cs_n == ecs, "R2", "cs_n", {24'h0, cs_n}, {24'h0, ecs});
      chk(ack == (k == w), "R5", "ack", {31'h0, ack}, {31'h0, k == w});
      chk(be_n == ((k <= w) ? ~ln : 4'hF), "R8", "be_n", {28'h0, be_n},
          {28'h0, (k <= w) ? ~ln : 4'hF});
      chk(oe_n == !((k <= w) && rd), "R9", "oe_n", {31'h0, oe_n},
          {31'h0, !((k <= w) && rd)});
      if (probe && k == 0) begin
        bus_start = 1'b1; bus_addr = pa; bus_type = t;
      end
      @(negedge clk);
      bus_start = 1'b0;
    end
    if (probe) check_idle("R11", 3);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int unused_seed;
    unused_seed = $urandom(32'd7321);
    for (int i = 0; i < 8; i++) begin
      m_valid[i] = 0; m_base[i] = '0; m_size[i] = 0; m_port[i] = 0;
      m_type[i] = '0; m_tmask[i] = '0; m_wait[i] = 0;
    end
    m_valid[0] = 1; m_base[0] = 32'hF000_0000; m_size[0] = 13; m_wait[0] = 20;

    repeat (3) @(negedge clk);
    // R1: outputs inactive while reset is held and right after release
    chk(cs_n == 8'hFF && ack == 1'b0, "R1", "reset cs/ack", {23'h0, ack, cs_n}, 32'hFF);
    chk(be_n == 4'hF && oe_n, "R1", "reset be/oe", {27'h0, oe_n, be_n}, 32'h1F);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n == 8'hFF && be_n == 4'hF && oe_n && !ack, "R1", "after release",
        {23'h0, ack, cs_n}, 32'hFF);

    // R1: boot bank answers at the top of memory, 20 waits, 8-bit port
    access(32'hF000_1236, 3'd5, 1'b1, 2, 1'b0, '0);
    access(32'hFFFF_FFFC, 3'd2, 1'b0, 0, 1'b0, '0);
    // R10: nothing decodes low memory yet
    access(32'h0000_0000, 3'd0, 1'b1, 2, 1'b0, '0);

    // R2: 32 KB bank at zero, no waits, 32-bit port, strict type 1
    cfg_write(1, 1, 32'h0000_0000, 0, 2, 3'd1, 3'd7, 0);
    access(32'h0000_7FFC, 3'd1, 1'b1, 2, 1'b0, '0);
    access(32'h0000_8000, 3'd1, 1'b1, 2, 1'b0, '0);   // R2 edge, R10
    access(32'h0000_0010, 3'd2, 1'b1, 2, 1'b0, '0);   // R3 type mismatch

    // R4: overlapping 1 MB bank 2, 16-bit port, 3 waits, any type
    cfg_write(2, 1, 32'h0000_0000, 5, 1, 3'd0, 3'd0, 3);
    access(32'h0000_0100, 3'd1, 1'b1, 2, 1'b0, '0);   // bank 1 wins
    access(32'h0000_0100, 3'd6, 1'b1, 2, 1'b0, '0);   // R3 falls to bank 2
    access(32'h0000_8002, 3'd1, 1'b0, 1, 1'b0, '0);   // R8 halfword on 16-bit
    access(32'h0000_8001, 3'd1, 1'b1, 0, 1'b0, '0);   // R8 byte lane 1

    // R6: wait count 31 behaves as 20
    cfg_write(3, 1, 32'h2000_0000, 2, 3, 3'd4, 3'd4, 31);
    access(32'h2001_0003, 3'd5, 1'b0, 0, 1'b0, '0);   // R9 write, lane 3
    access(32'h2001_0002, 3'd0, 1'b1, 1, 1'b0, '0);   // R3 bit2 mismatch

    // R7: size 15 behaves as 13
    cfg_write(4, 1, 32'h4000_0000, 15, 2, 3'd0, 3'd0, 1);
    access(32'h4FFF_FFF0, 3'd3, 1'b1, 1, 1'b0, '0);
    access(32'h5000_0000, 3'd3, 1'b1, 2, 1'b0, '0);

    // R12: a cleared bank is skipped
    cfg_write(1, 0, 32'h0000_0000, 0, 2, 3'd1, 3'd7, 0);
    access(32'h0000_0100, 3'd1, 1'b1, 2, 1'b0, '0);

    // R11: strobe during a transfer is ignored
    access(32'h2000_0040, 3'd4, 1'b1, 2, 1'b1, 32'h0000_0200);
    cfg_write(5, 1, 32'h6000_0000, 1, 2, 3'd0, 3'd0, 0);
    access(32'h6000_0004, 3'd0, 1'b1, 2, 1'b1, 32'h6000_0008);

    // Random settings and traffic
    for (int b = 1; b < 8; b++) begin
      cfg_write(b, ($urandom % 4) != 0, $urandom, $urandom % 16, $urandom % 4,
                3'($urandom), 3'($urandom), $urandom % 32);
    end
    for (int n = 0; n < 80; n++) begin
      int b, s;
      logic [31:0] a;
      logic [2:0]  t;
      b = $urandom % 8;
      s = 15 + m_size[b];
      a = ((m_base[b] >> s) << s) | ($urandom & ((32'h1 << s) - 1));
      if (($urandom % 5) == 0) a = $urandom;
      t = (($urandom % 2) == 0) ? m_type[b] : 3'($urandom);
      access(a, t, 1'($urandom), $urandom % 4, ($urandom % 6) == 0, $urandom);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule